// File: doc/BRIEF.md
# Chained Destination-Tag Stage Router

This block makes the routing decision for one switch in a middle stage of an eight-endpoint multistage network. Each middle stage has same-stage chaining links. The caller presents a request. The request carries the index of the current switch, the stage number, the destination bit for that stage, the variant of the path, and two fault flags. The variant is either the upward path or the downward path. One fault flag covers the forward link that the decision would use. The other covers the chaining link of the switch. One clock cycle later the block returns a one-hot output port and the index of the switch that the packet reaches next.

In stages 1 to n-1, a single destination bit decides between the straight link and the non-straight link. The non-straight link moves the packet by 2^i switches. The upward variant moves it up and the downward variant moves it down. If the chosen forward link is faulty, the packet takes the chaining link to a switch of the same stage. That switch lies 2^i positions away in the direction opposite to the variant. There is no backtracking. Stage 0 is steered by a two-bit code supplied by the caller. If no usable link is left, the block raises a drop flag.

Top module: `chain_stage_router`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, rsp_valid, port_sel and drop are all 0.
- R2: Every cycle with req_valid high produces a response with rsp_valid high exactly one clock later. A cycle with req_valid low produces rsp_valid low one clock later.
- R3: Up variant (model_down=0), stage i in 1..n-1, fault-free. If bit i of sw_idx differs from dest_bit, port_sel is non-straight and next_idx is (sw_idx + 2^i) mod 8. Otherwise port_sel is straight and next_idx is sw_idx.
- R4: Down variant (model_down=1), stage i in 1..n-1, fault-free. The condition is the same as in R3, but the non-straight next_idx is (sw_idx - 2^i) mod 8.
- R5: Stage i in 1..n-1 with fwd_fault=1 and chain_fault=0. port_sel is chain and next_idx is (sw_idx - 2^i) mod 8 for the up variant, or (sw_idx + 2^i) mod 8 for the down variant. When fwd_fault=0, chain_fault has no effect.
- R6: Stage i in 1..n-1 with both fault flags set. drop is 1, port_sel is 0 and next_idx equals sw_idx.
- R7: port_sel bit 0 is straight, bit 1 is non-straight and bit 2 is chain. In any response with drop low, exactly one bit is set.
- R8: At stage 0 only s0_code steers the decision. Code 00 gives non-straight to sw_idx-1, code 01 gives straight, code 10 gives straight, and code 11 gives non-straight to sw_idx+1, all mod 8. dest_bit and model_down are ignored at stage 0. Stage 0 has no chaining link, so fwd_fault=1 there gives drop regardless of chain_fault.
- R9: A stage number of n or higher gives drop with port_sel 0 and next_idx equal to sw_idx.
- R10: A response with rsp_valid low carries port_sel 0 and drop 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| sw_idx | input | IDX_W | Index of the current switch |
| stage | input | STG_W | Stage number of the current switch |
| dest_bit | input | 1 | Destination bit for this stage |
| model_down | input | 1 | 0 selects the up variant, 1 selects the down variant |
| s0_code | input | 2 | Two-bit steering code used at stage 0 |
| fwd_fault | input | 1 | The chosen forward link is faulty |
| chain_fault | input | 1 | The chaining link of this switch is faulty |
| rsp_valid | output | 1 | A response is present |
| port_sel | output | 3 | One-hot port: bit 0 straight, bit 1 non-straight, bit 2 chain |
| next_idx | output | IDX_W | Index of the switch reached next |
| drop | output | 1 | No usable link; the packet is dropped |

## Verification
The assertions assume that the fault flags and the request fields hold steady within the cycle in which req_valid is high. They also assume that rst_n is low for at least one clock edge before the first request. The stimulus meets both conditions. It changes inputs only on falling edges, starts with a reset lasting several cycles, and then sweeps every combination of switch index, stage (including the out-of-range value), destination bit, variant, stage-0 code and fault flags. Each expected port and index is computed with modular arithmetic on plain integers.

// File: rtl/chain_router_pkg.sv
// Shared encodings for the chained stage router.
// Assumes: a port vector of three bits, one bit per outgoing link kind.
package chain_router_pkg;
    localparam int PORT_W      = 3;
    localparam int PORT_STRAIT = 0;
    localparam int PORT_CROSS  = 1;
    localparam int PORT_CHAIN  = 2;

    typedef enum logic {
        VAR_UP   = 1'b0,
        VAR_DOWN = 1'b1
    } path_var_e;
endpackage

// File: rtl/crt_fwd_pick.sv
// Forward-link decision of one switch: straight or non-straight, and target index.
// Assumes: stage 0 is steered by a two-bit code and later stages by one destination bit.
// Stages at or beyond IDX_W are flagged through stage_ok and must not be used.
module crt_fwd_pick
    import chain_router_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int STG_W = 2
) (
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [STG_W-1:0]  stage,
    input  logic              dest_bit,
    input  path_var_e         path_var,
    input  logic [1:0]        s0_code,
    output logic [PORT_W-1:0] fwd_port,
    output logic [IDX_W-1:0]  fwd_idx,
    output logic              stage_ok,
    output logic              has_chain
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] idx_sh;
    logic             go_cross;
    logic             go_up;

    // Derive the per-stage distance, the stage's own index bit and range flags.
    always_comb begin
        step      = ONE << stage;
        idx_sh    = sw_idx >> stage;
        stage_ok  = (32'(stage) < IDX_W);
        has_chain = (stage != '0);
    end

    // Pick the link kind and direction for stage 0 (code) or later stages (dest bit).
    always_comb begin
        if (stage == '0) begin
            go_cross = (s0_code[1] == s0_code[0]);
            go_up    = s0_code[1];
        end else begin
            go_cross = idx_sh[0] ^ dest_bit;
            go_up    = (path_var == VAR_UP);
        end
    end

    // Form the one-hot forward port and the wrapped target index.
    always_comb begin
        fwd_port = '0;
        if (go_cross) begin
            fwd_port[PORT_CROSS] = 1'b1;
            if (stage == '0) begin
                fwd_idx = go_up ? sw_idx + ONE : sw_idx - ONE;
            end else begin
                fwd_idx = go_up ? sw_idx + step : sw_idx - step;
            end
        end else begin
            fwd_port[PORT_STRAIT] = 1'b1;
            fwd_idx               = sw_idx;
        end
    end
endmodule

// File: rtl/crt_chain_pick.sv
// Same-stage chaining target: distance 2^stage, opposite to the path variant.
// Assumes: only meaningful for stages 1..IDX_W-1; the caller masks other stages.
module crt_chain_pick
    import chain_router_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int STG_W = 2
) (
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [STG_W-1:0] stage,
    input  path_var_e        path_var,
    output logic [IDX_W-1:0] chain_idx
);
    logic [IDX_W-1:0] step;

    // Wrapped chain target, computed in parallel with the forward decision.
    always_comb begin
        step      = IDX_W'(1) << stage;
        chain_idx = (path_var == VAR_UP) ? sw_idx - step : sw_idx + step;
    end
endmodule

// File: rtl/crt_out_reg.sv
// Response register: holds one decision per cycle, cleared by reset.
// Assumes: synchronous active-low reset; inputs already settled for the cycle.
module crt_out_reg
    import chain_router_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [PORT_W-1:0] d_port,
    input  logic [IDX_W-1:0]  d_idx,
    input  logic              d_drop,
    output logic              q_valid,
    output logic [PORT_W-1:0] q_port,
    output logic [IDX_W-1:0]  q_idx,
    output logic              q_drop
);
    // Capture the combinational decision, or clear everything in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_port  <= '0;
            q_idx   <= '0;
            q_drop  <= 1'b0;
        end else begin
            q_valid <= d_valid;
            q_port  <= d_port;
            q_idx   <= d_idx;
            q_drop  <= d_drop;
        end
    end
endmodule

// File: rtl/chain_stage_router.sv
// Top of the chained destination-tag stage router.
// Picks straight, non-straight or chaining output for one switch and reports the
// next switch index, one cycle after the request. Assumes a fault flag describes the
// forward link the decision would choose; no backtracking is ever requested.
module chain_stage_router
    import chain_router_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int STG_W = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [STG_W-1:0]  stage,
    input  logic              dest_bit,
    input  logic              model_down,
    input  logic [1:0]        s0_code,
    input  logic              fwd_fault,
    input  logic              chain_fault,
    output logic              rsp_valid,
    output logic [2:0]        port_sel,
    output logic [IDX_W-1:0]  next_idx,
    output logic              drop
);
    path_var_e         path_var;
    logic [PORT_W-1:0] fwd_port;
    logic [IDX_W-1:0]  fwd_idx;
    logic [IDX_W-1:0]  chain_idx;
    logic              stage_ok;
    logic              has_chain;
    logic [PORT_W-1:0] dec_port;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_drop;

    // Map the variant pin onto the shared type.
    always_comb path_var = model_down ? VAR_DOWN : VAR_UP;

    crt_fwd_pick #(.IDX_W(IDX_W), .STG_W(STG_W)) fwd_i (
        .sw_idx    (sw_idx),
        .stage     (stage),
        .dest_bit  (dest_bit),
        .path_var  (path_var),
        .s0_code   (s0_code),
        .fwd_port  (fwd_port),
        .fwd_idx   (fwd_idx),
        .stage_ok  (stage_ok),
        .has_chain (has_chain)
    );

    crt_chain_pick #(.IDX_W(IDX_W), .STG_W(STG_W)) chain_i (
        .sw_idx    (sw_idx),
        .stage     (stage),
        .path_var  (path_var),
        .chain_idx (chain_idx)
    );

    // Fault resolution: forward link first, then chain, otherwise drop.
    always_comb begin
        dec_port = '0;
        dec_idx  = sw_idx;
        dec_drop = 1'b0;
        if (req_valid) begin
            if (!stage_ok) begin
                dec_drop = 1'b1;
            end else if (!fwd_fault) begin
                dec_port = fwd_port;
                dec_idx  = fwd_idx;
            end else if (has_chain && !chain_fault) begin
                dec_port[PORT_CHAIN] = 1'b1;
                dec_idx              = chain_idx;
            end else begin
                dec_drop = 1'b1;
            end
        end
    end

    crt_out_reg #(.IDX_W(IDX_W)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (req_valid),
        .d_port  (dec_port),
        .d_idx   (dec_idx),
        .d_drop  (dec_drop),
        .q_valid (rsp_valid),
        .q_port  (port_sel),
        .q_idx   (next_idx),
        .q_drop  (drop)
    );
endmodule

// File: rtl/chain_stage_router_chk.sv
// Checker for the chained stage router, attached by bind.
// Assumes: request fields are stable across the cycle in which req_valid is high.
module chain_stage_router_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] sw_idx,
    input logic             fwd_fault,
    input logic             rsp_valid,
    input logic [2:0]       port_sel,
    input logic [IDX_W-1:0] next_idx,
    input logic             drop
);
    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !drop) |-> ($countones(port_sel) == 1)); // R7
    AST_DROP_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (port_sel == 3'b000)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (port_sel == 3'b000 && !drop)); // R10
    AST_STRAIGHT_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fwd_fault) |=> (!port_sel[0] || next_idx == $past(sw_idx))); // R3
    AST_CHAIN_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fwd_fault) |=> !port_sel[2]); // R5
endmodule

bind chain_stage_router chain_stage_router_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .sw_idx    (sw_idx),
    .fwd_fault (fwd_fault),
    .rsp_valid (rsp_valid),
    .port_sel  (port_sel),
    .next_idx  (next_idx),
    .drop      (drop)
);

// File: tb/chain_stage_router_tb_top.sv
// Exhaustive sweep bench for the chained stage router (IDX_W = 3, eight switches).
module chain_stage_router_tb_top;
    localparam int IDX_W = 3;
    localparam int STG_W = 2;
    localparam int NSW   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [IDX_W-1:0] sw_idx = '0;
    logic [STG_W-1:0] stage = '0;
    logic             dest_bit = 1'b0;
    logic             model_down = 1'b0;
    logic [1:0]       s0_code = '0;
    logic             fwd_fault = 1'b0;
    logic             chain_fault = 1'b0;
    logic             rsp_valid;
    logic [2:0]       port_sel;
    logic [IDX_W-1:0] next_idx;
    logic             drop;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    chain_stage_router #(.IDX_W(IDX_W), .STG_W(STG_W)) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .sw_idx (sw_idx),
        .stage (stage), .dest_bit (dest_bit), .model_down (model_down),
        .s0_code (s0_code), .fwd_fault (fwd_fault), .chain_fault (chain_fault),
        .rsp_valid (rsp_valid), .port_sel (port_sel), .next_idx (next_idx),
        .drop (drop)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1 port_sel in reset", int'(port_sel), 0);
        chk("R1 drop in reset", int'(drop), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk("R10 idle port_sel", int'(port_sel), 0);
        chk("R10 idle drop", int'(drop), 0);

        for (int st = 0; st < 4; st++)
        for (int j = 0; j < NSW; j++)
        for (int d = 0; d < 2; d++)
        for (int m = 0; m < 2; m++)
        for (int c = 0; c < 4; c++)
        for (int ff = 0; ff < 2; ff++)
        for (int cf = 0; cf < 2; cf++) begin
            int e_port;
            int e_idx;
            int e_drop;
            int step;
            step = 1 << st;
            e_port = 0; e_idx = j; e_drop = 0;
            if (st >= IDX_W) begin
                e_drop = 1;                                   // R9
            end else if (st == 0) begin
                if (ff == 1) e_drop = 1;                      // R8 no chain at stage 0
                else if (c == 0) begin e_port = 2; e_idx = (j + NSW - 1) % NSW; end
                else if (c == 3) begin e_port = 2; e_idx = (j + 1) % NSW; end
                else e_port = 1;
            end else if (ff == 0) begin
                if ((((j >> st) & 1) ^ d) == 1) begin
                    e_port = 2;
                    e_idx  = (m == 0) ? (j + step) % NSW : (j + NSW - step) % NSW; // R3 R4
                end else e_port = 1;
            end else if (cf == 0) begin
                e_port = 4;
                e_idx  = (m == 0) ? (j + NSW - step) % NSW : (j + step) % NSW;     // R5
            end else e_drop = 1;                              // R6

            sw_idx = IDX_W'(j); stage = STG_W'(st); dest_bit = d[0];
            model_down = m[0]; s0_code = c[1:0]; fwd_fault = ff[0];
            chain_fault = cf[0]; req_valid = 1'b1;
            @(negedge clk);
            chk("R2 rsp_valid", int'(rsp_valid), 1);
            if (st >= IDX_W) begin
                chk("R9 port_sel", int'(port_sel), e_port);
                chk("R9 drop", int'(drop), e_drop);
                chk("R9 next_idx", int'(next_idx), e_idx);
            end else if (st == 0) begin
                chk("R8 port_sel", int'(port_sel), e_port);
                chk("R8 drop", int'(drop), e_drop);
                chk("R8 next_idx", int'(next_idx), e_idx);
            end else if (ff == 0 && m == 0) begin
                chk("R3 port_sel", int'(port_sel), e_port);
                chk("R3 next_idx", int'(next_idx), e_idx);
                chk("R5 no drop on good link", int'(drop), 0);
            end else if (ff == 0) begin
                chk("R4 port_sel", int'(port_sel), e_port);
                chk("R4 next_idx", int'(next_idx), e_idx);
                chk("R7 no drop on good link", int'(drop), 0);
            end else if (cf == 0) begin
                chk("R5 port_sel", int'(port_sel), e_port);
                chk("R5 next_idx", int'(next_idx), e_idx);
                chk("R5 drop", int'(drop), 0);
            end else begin
                chk("R6 drop", int'(drop), 1);
                chk("R6 port_sel", int'(port_sel), 0);
                chk("R6 next_idx", int'(next_idx), e_idx);
            end
            if (e_drop == 0) chk("R7 one-hot", $countones(port_sel), 1);
        end

        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 rsp_valid after gap", int'(rsp_valid), 0);
        chk("R10 port_sel after gap", int'(port_sel), 0);
        chk("R10 drop after gap", int'(drop), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule